// File: doc/BRIEF.md
# DMA Channel Multi-Buffer Sequencer

This block is one DMA channel. Software programs a source address, a destination address, a buffer size counted in data items, the source and destination item widths, and an address mode for each side. Writing the start bit then launches the transfer. The channel moves items one at a time over a single valid/ready memory port. It first reads an item from the source, then writes that item to the destination, and steps each address by its own width in its own direction.

When the last item of a buffer has been written, the channel takes one of three paths:
- **Descriptor fetch.** If the next-descriptor pointer is non-zero, it reads a four-word descriptor from memory at that pointer and starts the buffer that descriptor describes.
- **Auto repeat.** If the pointer is zero and auto mode is on, it restores the original addresses and size from saved copies and runs the same buffer again.
- **Stop.** Otherwise it stops.

Every finished buffer sets a buffer-done pending bit. Stopping sets a chain-done pending bit. Each pending bit drives its own interrupt line through its own mask bit. Reading the status register returns the pending bits and clears them.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `irq_buf` and `irq_chain` are 0, and the status register (select 6) reads 0.
- R2: Each item is read at the source address with `mem_size` = source width and written at the destination address with `mem_size` = destination width. Width codes are 0 = byte, 1 = halfword, 2 = word. The item travels in the low bits of the data bus, cut to the source width and zero-extended. After each item, each address steps by its own width in bytes. Mode codes are 0 = increment, 1 = decrement, 2 = fixed.
- R3: Status bit 0 (buffer done) is set in the cycle in which the write of a buffer's last item is accepted, and never on a read.
- R4: Status bit 1 (chain done) is set only when the channel stops, in the same cycle that `busy` falls.
- R5: `irq_buf` is status bit 0 ANDed with mask bit 0, and `irq_chain` is status bit 1 ANDed with mask bit 1. The mask is at select 5. A pending bit that is set while its mask bit is 0 raises its line as soon as the mask bit is set.
- R6: A read of select 6 returns the pending bits in data bits [1:0] and clears them.
- R7: At the end of a buffer, if the next-descriptor pointer (select 2) is zero and auto (control B bit 0) is 0, the channel stops.
- R8: At the end of a buffer, if the pointer is zero and auto is 1, the channel reloads the start source address, start destination address and size, and repeats the buffer. The buffer that ends after auto has been cleared is the last one.
- R9: At the end of a buffer, if the pointer is non-zero, the channel reads four words at pointer +0, +4, +8 and +12, in that order. These words are the source, destination, control A and next pointer. The channel then runs that buffer. A chain stops after a buffer whose descriptor carried a zero pointer, when auto is 0.
- R10: `busy`, and bit 0 of select 4, read 1 from the start write (select 4, bit 0 = 1) until the channel stops. A start write while busy is ignored, and `mem_req` is 0 while idle.
- R11: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ready` is 1.
- R12: While busy, writes to source, destination, pointer and control A (selects 0 to 3) are ignored. Writes to control B (select 4 is start; select 3 is control A, select 7 is control B) take effect at once. Control A holds the size in [15:0], the source width in [17:16] and the destination width in [21:20]. Control B holds auto in [0], the source mode in [5:4] and the destination mode in [9:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is returned on the next cycle |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, low-aligned; valid with `mem_ready` |
| mem_ready | input | 1 | Request accepted this cycle |
| irq_buf | output | 1 | Masked buffer-done interrupt |
| irq_chain | output | 1 | Masked chain-done interrupt |
| busy | output | 1 | Channel active |

## Verification
The checker takes for granted that memory holds `mem_rdata` valid whenever it asserts `mem_ready`. It also assumes that software programs a buffer size of at least one item and widths no larger than a word. The stimulus keeps to these assumptions:
- The bench memory model answers every request with a repeating ready pattern that stalls one cycle in three.
- Every size the bench programs is between 1 and 4.
- Every width code the bench programs is 0, 1 or 2.

A status read is issued only while the channel is between buffer ends, so no set and clear of the same bit meet in one cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FETCH} chan_st_t;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_NXT  = 3'd2;
  localparam logic [2:0] SEL_CTA  = 3'd3;
  localparam logic [2:0] SEL_GO   = 3'd4;
  localparam logic [2:0] SEL_MASK = 3'd5;
  localparam logic [2:0] SEL_STAT = 3'd6;
  localparam logic [2:0] SEL_CTB  = 3'd7;

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] d, input logic [1:0] w);
    case (w)
      2'd0:    keep_low = {24'd0, d[7:0]};
      2'd1:    keep_low = {16'd0, d[15:0]};
      default: keep_low = d;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  input  logic [1:0]        width,
  output logic [ADDR_W-1:0] nxt
);
  import dma_seq_pkg::*;
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = ADDR_W'(width_bytes(width));
    case (mode)
      2'd0:    nxt = cur + step;
      2'd1:    nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int EV_N = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_N-1:0] set_ev,
  input  logic            clr,
  input  logic [EV_N-1:0] mask,
  output logic [EV_N-1:0] pend,
  output logic [EV_N-1:0] irq
);
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (clr ? '0 : pend) | set_ev;
  end

  for (genvar i = 0; i < EV_N; i++) begin : g_line
    assign irq[i] = pend[i] & mask[i];
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              irq_buf,
  output logic              irq_chain,
  output logic              busy
);
  import dma_seq_pkg::*;
  localparam int SW_LSB = 16;
  localparam int DW_LSB = 20;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  chan_st_t          state;
  logic [ADDR_W-1:0] src_q, dst_q, nxt_q, sh_src, sh_dst;
  logic [CNT_W-1:0]  cnt_q, sh_cnt;
  logic [1:0]        sw_q, dw_q, sm_q, dm_q, mask_q, fidx;
  logic              auto_q;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] src_nx, dst_nx;
  logic [1:0]        pend_w, irq_w;
  logic              hs, last, buf_set, chain_set, stat_clr;

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (.cur(src_q), .mode(sm_q), .width(sw_q), .nxt(src_nx));
  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (.cur(dst_q), .mode(dm_q), .width(dw_q), .nxt(dst_nx));

  assign busy      = (state != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WRITE);
  assign mem_wdata = data_q;
  assign hs        = mem_req && mem_ready;
  assign last      = (cnt_q == ONE);
  assign buf_set   = (state == ST_WRITE) && hs && last;
  assign chain_set = buf_set && (nxt_q == '0) && !auto_q;
  assign stat_clr  = reg_rd && (reg_sel == SEL_STAT);

  always_comb begin
    case (state)
      ST_READ:  begin mem_addr = src_q; mem_size = sw_q; end
      ST_WRITE: begin mem_addr = dst_q; mem_size = dw_q; end
      ST_FETCH: begin mem_addr = nxt_q + ADDR_W'({fidx, 2'b00}); mem_size = 2'd2; end
      default:  begin mem_addr = '0;    mem_size = 2'd2; end
    endcase
  end

  dma_irq_ctrl #(.EV_N(2)) u_irq (
    .clk(clk), .rst(rst), .set_ev({chain_set, buf_set}), .clr(stat_clr),
    .mask(mask_q), .pend(pend_w), .irq(irq_w)
  );
  assign irq_buf   = irq_w[0];
  assign irq_chain = irq_w[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      src_q <= '0; dst_q <= '0; nxt_q <= '0; sh_src <= '0; sh_dst <= '0;
      cnt_q <= '0; sh_cnt <= '0; sw_q <= '0; dw_q <= '0; sm_q <= '0; dm_q <= '0;
      mask_q <= '0; fidx <= '0; auto_q <= 1'b0; data_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          SEL_SRC: if (!busy) src_q <= reg_wdata[ADDR_W-1:0];
          SEL_DST: if (!busy) dst_q <= reg_wdata[ADDR_W-1:0];
          SEL_NXT: if (!busy) nxt_q <= reg_wdata[ADDR_W-1:0];
          SEL_CTA: if (!busy) begin
            cnt_q <= reg_wdata[CNT_W-1:0];
            sw_q  <= reg_wdata[SW_LSB+:2];
            dw_q  <= reg_wdata[DW_LSB+:2];
          end
          SEL_CTB: begin
            auto_q <= reg_wdata[0];
            sm_q   <= reg_wdata[5:4];
            dm_q   <= reg_wdata[9:8];
          end
          SEL_GO: if (!busy && reg_wdata[0]) begin
            state  <= ST_READ;
            sh_src <= src_q; sh_dst <= dst_q; sh_cnt <= cnt_q;
          end
          SEL_MASK: mask_q <= reg_wdata[1:0];
          default: ;
        endcase
      end
      case (state)
        ST_READ: if (hs) begin
          data_q <= keep_low(mem_rdata, sw_q);
          src_q  <= src_nx;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (hs) begin
          dst_q <= dst_nx;
          cnt_q <= cnt_q - ONE;
          if (!last) state <= ST_READ;
          else if (nxt_q != '0) begin
            state <= ST_FETCH;
            fidx  <= 2'd0;
          end else if (auto_q) begin
            src_q <= sh_src; dst_q <= sh_dst; cnt_q <= sh_cnt;
            state <= ST_READ;
          end else state <= ST_IDLE;
        end
        ST_FETCH: if (hs) begin
          fidx <= fidx + 2'd1;
          case (fidx)
            2'd0: begin src_q <= mem_rdata[ADDR_W-1:0]; sh_src <= mem_rdata[ADDR_W-1:0]; end
            2'd1: begin dst_q <= mem_rdata[ADDR_W-1:0]; sh_dst <= mem_rdata[ADDR_W-1:0]; end
            2'd2: begin
              cnt_q  <= mem_rdata[CNT_W-1:0];
              sh_cnt <= mem_rdata[CNT_W-1:0];
              sw_q   <= mem_rdata[SW_LSB+:2];
              dw_q   <= mem_rdata[DW_LSB+:2];
            end
            default: begin nxt_q <= mem_rdata[ADDR_W-1:0]; state <= ST_READ; end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_sel)
        SEL_SRC:  reg_rdata <= 32'(src_q);
        SEL_DST:  reg_rdata <= 32'(dst_q);
        SEL_NXT:  reg_rdata <= 32'(nxt_q);
        SEL_CTA:  reg_rdata <= 32'(cnt_q) | (32'(sw_q) << SW_LSB) | (32'(dw_q) << DW_LSB);
        SEL_GO:   reg_rdata <= {31'd0, busy};
        SEL_MASK: reg_rdata <= {30'd0, mask_q};
        SEL_STAT: reg_rdata <= {30'd0, pend_w};
        default:  reg_rdata <= {22'd0, dm_q, 2'd0, sm_q, 3'd0, auto_q};
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              busy,
  input logic [1:0]        pend_w
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R3
  buf_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_w[0]) |-> $past(mem_req && mem_we && mem_ready));

  // R4
  chain_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_w[1]) |-> (!busy && $past(busy)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .pend_w(pend_w)
);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ready = 0, irq_buf, irq_chain, busy;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;

  dma_chan_seq #(.ADDR_W(AW), .CNT_W(16)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq_buf(irq_buf), .irq_chain(irq_chain), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: bytes, source pattern below 0x200, descriptors at 0x200..0x21F
  logic [7:0]  mem [0:1023];
  logic [7:0]  exp_m [0:1023];
  logic [31:0] desc_w [0:7];
  logic        clr = 0;
  int          wr_cnt, fetch_cnt, fetch_bad, cyc;

  function automatic logic [7:0] init_byte(input int a);
    return (a < 'h200) ? 8'((a * 7 + 3) & 255) : 8'd0;
  endfunction

  always_comb begin
    if (mem_addr[9:5] == 5'b10000) mem_rdata = desc_w[mem_addr[4:2]];
    else mem_rdata = {mem[(mem_addr + 3) & 1023], mem[(mem_addr + 2) & 1023],
                      mem[(mem_addr + 1) & 1023], mem[mem_addr & 1023]};
  end

  always @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_byte(i);
      wr_cnt <= 0; fetch_cnt <= 0; fetch_bad <= 0;
    end else if (mem_req && mem_ready) begin
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int k = 0; k < (1 << mem_size); k++) mem[(mem_addr + k) & 1023] <= mem_wdata[8*k +: 8];
      end else if (mem_addr[9:5] == 5'b10000) begin
        if (mem_addr[4:0] != 5'(fetch_cnt * 4)) fetch_bad <= fetch_bad + 1;
        fetch_cnt <= fetch_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (cyc % 3) != 2;
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_sel = s;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000 && !irq_buf; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    for (int i = 0; i < 1024; i++) exp_m[i] = 0;
  endtask

  task automatic model_buf(input int s, input int d, input int n, input int sw, input int dw,
                           input int sm, input int dm);
    int sa = s, da = d;
    for (int i = 0; i < n; i++) begin
      logic [31:0] v = 0;
      for (int k = 0; k < (1 << sw); k++) v |= 32'(init_byte((sa + k) & 1023)) << (8 * k);
      for (int k = 0; k < (1 << dw); k++) exp_m[(da + k) & 1023] = v[8*k +: 8];
      if (sm == 0) sa += (1 << sw); else if (sm == 1) sa -= (1 << sw);
      if (dm == 0) da += (1 << dw); else if (dm == 1) da -= (1 << dw);
    end
  endtask

  task automatic compare_dst(input string req, input string what);
    int bad = 0, first = -1;
    for (int a = 'h280; a < 1024; a++)
      if (mem[a] !== exp_m[a]) begin bad++; if (first < 0) first = a; end
    chk(bad == 0, req, what, first, -1);
  endtask

  function automatic logic [31:0] cta(input int n, input int sw, input int dw);
    return 32'(n) | (32'(sw) << 16) | (32'(dw) << 20);
  endfunction

  function automatic logic [31:0] ctb(input int au, input int sm, input int dm);
    return 32'(au) | (32'(sm) << 4) | (32'(dm) << 8);
  endfunction

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 8; i++) desc_w[i] = 0;
    desc_w[0] = 'h20;  desc_w[1] = 'h2A0; desc_w[2] = cta(3, 1, 1); desc_w[3] = 'h210;
    desc_w[4] = 'h30;  desc_w[5] = 'h2C0; desc_w[6] = cta(1, 0, 2); desc_w[7] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req, "R1", "busy/req after reset", {busy, mem_req}, 0);
    chk(!irq_buf && !irq_chain, "R1", "irq after reset", {irq_buf, irq_chain}, 0);
    reg_read(3'd6, rd);
    chk(rd == 0, "R1", "status after reset", rd, 0);

    // R2/R7 sweep of widths and address modes, single buffer of 3 items
    for (int sw = 0; sw < 3; sw++)
      for (int dw = 0; dw < 3; dw++)
        for (int sm = 0; sm < 3; sm++)
          for (int dm = 0; dm < 3; dm++) begin
            do_clear();
            model_buf('h100, 'h300, 3, sw, dw, sm, dm);
            reg_write(3'd0, 'h100); reg_write(3'd1, 'h300); reg_write(3'd2, 0);
            reg_write(3'd3, cta(3, sw, dw)); reg_write(3'd7, ctb(0, sm, dm));
            reg_write(3'd4, 1);
            wait_idle();
            compare_dst("R2", $sformatf("dst bytes sw%0d dw%0d sm%0d dm%0d", sw, dw, sm, dm));
            chk(wr_cnt == 3, "R7", "writes in single buffer", wr_cnt, 3);
            reg_read(3'd6, rd);
            chk(rd[1:0] == 2'b11, "R3", "status after single buffer", rd, 3);
          end
    reg_read(3'd6, rd);
    chk(rd == 0, "R6", "status cleared by read", rd, 0);

    // R5 mask gating
    do_clear();
    reg_write(3'd5, 0);
    reg_write(3'd0, 'h80); reg_write(3'd1, 'h300); reg_write(3'd2, 0);
    reg_write(3'd3, cta(2, 2, 2)); reg_write(3'd7, ctb(0, 0, 0)); reg_write(3'd4, 1);
    wait_idle();
    @(negedge clk);
    chk(!irq_buf && !irq_chain, "R5", "irq masked off", {irq_buf, irq_chain}, 0);
    reg_write(3'd5, 3);
    chk(irq_buf && irq_chain, "R5", "irq after unmask", {irq_buf, irq_chain}, 3);
    reg_read(3'd6, rd);
    chk(rd[1:0] == 2'b11, "R6", "status value read", rd, 3);
    @(negedge clk);
    chk(!irq_buf && !irq_chain, "R6", "irq after status read", {irq_buf, irq_chain}, 0);

    // R8 auto repeat: three repeats then clear auto during the fourth buffer
    do_clear();
    model_buf('h40, 'h380, 4, 2, 2, 0, 0);
    reg_write(3'd0, 'h40); reg_write(3'd1, 'h380); reg_write(3'd2, 0);
    reg_write(3'd3, cta(4, 2, 2)); reg_write(3'd7, ctb(1, 0, 0)); reg_write(3'd4, 1);
    for (int b = 0; b < 3; b++) begin
      wait_irq();
      reg_read(3'd6, rd);
      chk(rd[1:0] == 2'b01, "R8", $sformatf("status at repeat %0d", b), rd, 1);
      chk(busy, "R8", "still busy while auto on", busy, 1);
    end
    reg_write(3'd7, ctb(0, 0, 0));
    wait_idle();
    chk(wr_cnt == 16, "R8", "writes over four buffers", wr_cnt, 16);
    compare_dst("R8", "dst after auto repeat");
    reg_read(3'd6, rd);
    chk(rd[1:0] == 2'b11, "R8", "status after last buffer", rd, 3);

    // R9 linked list of three buffers
    do_clear();
    model_buf('h10, 'h280, 2, 2, 2, 0, 0);
    model_buf('h20, 'h2A0, 3, 1, 1, 0, 0);
    model_buf('h30, 'h2C0, 1, 0, 2, 0, 0);
    reg_write(3'd0, 'h10); reg_write(3'd1, 'h280); reg_write(3'd2, 'h200);
    reg_write(3'd3, cta(2, 2, 2)); reg_write(3'd7, ctb(0, 0, 0)); reg_write(3'd4, 1);
    wait_idle();
    chk(wr_cnt == 6, "R9", "writes over chain", wr_cnt, 6);
    chk(fetch_cnt == 8 && fetch_bad == 0, "R9", "descriptor reads in order", fetch_cnt, 8);
    compare_dst("R9", "dst after chain");
    reg_read(3'd6, rd);
    chk(rd[1:0] == 2'b11, "R9", "status after chain", rd, 3);

    // R10/R12 writes while busy
    do_clear();
    model_buf('h80, 'h300, 4, 2, 2, 0, 0);
    reg_write(3'd0, 'h80); reg_write(3'd1, 'h300); reg_write(3'd2, 0);
    reg_write(3'd3, cta(4, 2, 2)); reg_write(3'd7, ctb(0, 0, 0)); reg_write(3'd4, 1);
    reg_read(3'd4, rd);
    chk(rd[0] == 1'b1, "R10", "go bit reads busy", rd, 1);
    reg_write(3'd1, 'h380); reg_write(3'd2, 'h200); reg_write(3'd3, cta(9, 0, 0));
    reg_write(3'd4, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(!busy && wr_cnt == 4, "R10", "start while busy ignored", wr_cnt, 4);
    chk(fetch_cnt == 0, "R12", "pointer write while busy ignored", fetch_cnt, 0);
    compare_dst("R12", "dst/size writes while busy ignored");
    reg_read(3'd4, rd);
    chk(rd[0] == 1'b0, "R10", "go bit idle", rd, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule